// File: doc/BRIEF.md
# Successive Approximation Converter Controller

This block holds the digital side of a successive-approximation converter. A host reaches it through a small byte-wide register interface. Writing the start bit in the control register begins a conversion. The controller then walks through the bit trials, one bit per clock and most significant bit first. It drives the trial level to an external DAC and reads back one comparator bit each cycle.

When the last bit is resolved, the controller raises a sticky completion flag. It also stores the result as a 16-bit word that the host reads as a high byte and a low byte. A conversion resolves 8, 10 or 12 bits. The result is unsigned for single-ended inputs and two's complement for differential inputs. It is placed left- or right-aligned in the 16-bit word. The resolution, the input format and the alignment are captured when a conversion starts, so the host may rewrite them at any time without disturbing a conversion already under way.

Top module: `sar_ctrl`

## Requirements
- R1: The resolution field (control bits 6:5: 00 = 8 bits, 01 = 10 bits, 10 or 11 = 12 bits) sets the bit count n. The completion flag becomes visible after the n-th rising edge that follows the edge which accepted the start.
- R2: The busy bit (control bit 0) reads 1 from the edge that accepts a start until the edge that completes the conversion, and reads 0 after that.
- R3: The completion flag (control bit 1) reads 0 during a conversion and is set when the conversion completes. It then stays set until the host writes the control register with bit 1 equal to 0, or until the host starts a new conversion.
- R4: A start happens on a control write with bit 0 set and the start-mode field (bits 4:3) equal to 00 in that same write, while the block is idle. In the following cycle the trial level is 0x800, which is the MSB trial.
- R5: Writing the start bit while a conversion is running is ignored. The running conversion completes on its original schedule with an unchanged result.
- R6: With a nonzero start-mode field, writing the start bit does not begin a conversion.
- R7: Each cycle the bit under test is kept when the comparator input is 1, meaning the input is at or above the trial level. For a comparator that reports trial_code <= V, the unsigned code is floor(V / 2^(12-n)). The result is truncated, not rounded.
- R8: In single-ended mode (control bit 7 = 0) the result is the unsigned code. In differential mode (bit 7 = 1) it is the two's complement value code - 2^(n-1).
- R9: With right alignment (control bit 2 = 0) the value occupies bits n-1:0. The upper bits are zero in single-ended mode and copies of the sign in differential mode.
- R10: With left alignment (control bit 2 = 1) the value occupies bits 15:16-n, and the lower bits are zero.
- R11: The alignment, resolution and format in force are those written with the start. Writes made during a conversion change the control readback but affect only the next conversion.
- R12: Read address 0 returns the control byte {format, resolution, start mode, alignment, completion flag, busy}. Address 1 returns result bits 15:8, address 2 returns result bits 7:0, and address 3 returns 0.
- R13: After reset the control byte and the result both read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address (0 = control) |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 8 | Read data, combinational from rd_addr |
| cmp_i | input | 1 | Comparator: 1 when the input is at or above the trial level |
| trial_code | output | 12 | Trial level for the external DAC, MSB-aligned |

## Verification
The start write is taken at one edge, and the first trial level appears in the cycle after that. The busy bit and the completion flag change together at the n-th later edge. The bench counts falling edges from the start write and samples at that point. It checks busy = 1 and flag = 0 one cycle before completion, and the opposite one cycle after. It reads the result only once the flag is up. Writes made during a conversion are placed a few cycles into the run, and the check still expects completion at the original edge.

// File: rtl/sar_pkg.sv
package sar_pkg;
  localparam int CODE_W = 12;
  localparam int WORD_W = 16;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 2;
  localparam int CNT_W  = $clog2(CODE_W + 1);

  // control byte bit positions
  localparam int B_BUSY = 0;
  localparam int B_DONE = 1;
  localparam int B_JUST = 2;
  localparam int B_MODE = 3;
  localparam int B_RES  = 5;
  localparam int B_DIFF = 7;

  localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] A_HIGH = 2'd1;
  localparam logic [ADDR_W-1:0] A_LOW  = 2'd2;

  typedef struct packed {
    logic       diff;
    logic [1:0] res;
    logic       just;
  } run_cfg_t;

  function automatic logic [CNT_W-1:0] res_bits(input logic [1:0] sel);
    case (sel)
      2'b00:   return CNT_W'(8);
      2'b01:   return CNT_W'(10);
      default: return CNT_W'(12);
    endcase
  endfunction

  function automatic logic [CODE_W-1:0] lsb_mask(input logic [1:0] sel);
    return CODE_W'(1) << (CODE_W - int'(res_bits(sel)));
  endfunction

  // code12 holds the n resolved bits MSB-aligned, zeros below
  function automatic logic [WORD_W-1:0] pack_result(input logic [CODE_W-1:0] code12,
                                                   input run_cfg_t cfg);
    logic [CODE_W-1:0] c;
    logic [WORD_W-1:0] w;
    int sh;
    c = code12;
    if (cfg.diff) c[CODE_W-1] = ~c[CODE_W-1];
    w  = {c, {(WORD_W-CODE_W){1'b0}}};
    sh = WORD_W - int'(res_bits(cfg.res));
    if (cfg.just)      return w;
    else if (cfg.diff) return WORD_W'($signed(w) >>> sh);
    else               return w >> sh;
  endfunction
endpackage

// File: rtl/sar_regs.sv
module sar_regs
  import sar_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              busy,
  input  logic              conv_done,
  output logic              start_pulse,
  output logic              done_clr,
  output logic              done_q,
  output run_cfg_t          run_cfg,
  output logic [DATA_W-1:0] ctrl_byte
);
  logic       just_q, diff_q;
  logic [1:0] mode_q, res_q;
  logic       ctrl_wr;

  assign ctrl_wr     = wr_en && (wr_addr == A_CTRL);
  assign start_pulse = ctrl_wr && wr_data[B_BUSY] &&
                       (wr_data[B_MODE+1:B_MODE] == 2'b00) && !busy;
  assign done_clr    = start_pulse || (ctrl_wr && !wr_data[B_DONE]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      just_q  <= 1'b0;
      diff_q  <= 1'b0;
      mode_q  <= 2'b00;
      res_q   <= 2'b00;
      done_q  <= 1'b0;
      run_cfg <= '0;
    end else begin
      if (ctrl_wr) begin
        just_q <= wr_data[B_JUST];
        mode_q <= wr_data[B_MODE+1:B_MODE];
        res_q  <= wr_data[B_RES+1:B_RES];
        diff_q <= wr_data[B_DIFF];
      end
      if (conv_done)     done_q <= 1'b1;
      else if (done_clr) done_q <= 1'b0;
      if (start_pulse) begin
        run_cfg.diff <= wr_data[B_DIFF];
        run_cfg.res  <= wr_data[B_RES+1:B_RES];
        run_cfg.just <= wr_data[B_JUST];
      end
    end
  end

  assign ctrl_byte = {diff_q, res_q, mode_q, just_q, done_q, busy};
endmodule

// File: rtl/sar_seq.sv
module sar_seq
  import sar_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_pulse,
  input  logic [1:0]        res_sel,
  input  logic              cmp_i,
  output logic              busy,
  output logic              conv_done,
  output logic [CODE_W-1:0] trial_code,
  output logic [CODE_W-1:0] final_code
);
  localparam logic [CODE_W-1:0] MSB_BIT = CODE_W'(1) << (CODE_W - 1);

  logic [CODE_W-1:0] bit_q;
  logic [CODE_W-1:0] resolved;

  // keep the bit under test only if the input is at or above the trial level
  assign resolved   = cmp_i ? trial_code : (trial_code & ~bit_q);
  assign conv_done  = busy && (bit_q == lsb_mask(res_sel));
  assign final_code = resolved;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      bit_q      <= '0;
      trial_code <= '0;
    end else if (start_pulse) begin
      busy       <= 1'b1;
      bit_q      <= MSB_BIT;
      trial_code <= MSB_BIT;
    end else if (busy) begin
      if (conv_done) begin
        busy       <= 1'b0;
        bit_q      <= '0;
        trial_code <= resolved;
      end else begin
        bit_q      <= bit_q >> 1;
        trial_code <= resolved | (bit_q >> 1);
      end
    end
  end
endmodule

// File: rtl/sar_fmt.sv
module sar_fmt
  import sar_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              conv_done,
  input  logic [CODE_W-1:0] final_code,
  input  run_cfg_t          run_cfg,
  output logic [WORD_W-1:0] result_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         result_q <= '0;
    else if (conv_done) result_q <= pack_result(final_code, run_cfg);
  end
endmodule

// File: rtl/sar_ctrl.sv
module sar_ctrl
  import sar_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              cmp_i,
  output logic [CODE_W-1:0] trial_code
);
  logic              start_pulse;
  logic              done_clr;
  logic              done_q;
  logic              busy;
  logic              conv_done;
  run_cfg_t          run_cfg;
  logic [DATA_W-1:0] ctrl_byte;
  logic [CODE_W-1:0] final_code;
  logic [WORD_W-1:0] result_q;

  sar_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .busy(busy), .conv_done(conv_done), .start_pulse(start_pulse), .done_clr(done_clr),
    .done_q(done_q), .run_cfg(run_cfg), .ctrl_byte(ctrl_byte)
  );

  sar_seq u_seq (
    .clk(clk), .rst_n(rst_n), .start_pulse(start_pulse), .res_sel(run_cfg.res),
    .cmp_i(cmp_i), .busy(busy), .conv_done(conv_done), .trial_code(trial_code),
    .final_code(final_code)
  );

  sar_fmt u_fmt (
    .clk(clk), .rst_n(rst_n), .conv_done(conv_done), .final_code(final_code),
    .run_cfg(run_cfg), .result_q(result_q)
  );

  always_comb begin
    case (rd_addr)
      A_CTRL:  rd_data = ctrl_byte;
      A_HIGH:  rd_data = result_q[WORD_W-1:DATA_W];
      A_LOW:   rd_data = result_q[DATA_W-1:0];
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/sar_ctrl_chk.sv
module sar_ctrl_chk
  import sar_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              start_pulse,
  input logic              conv_done,
  input logic              done_clr,
  input logic              busy,
  input logic              done_q,
  input logic [CODE_W-1:0] trial_code,
  input logic [WORD_W-1:0] result_q,
  input run_cfg_t          run_cfg
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (start_pulse) cnt <= '0;
    else if (busy)        cnt <= cnt + 1'b1;
  end

  // R1
  trial_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done |-> cnt == CNT_W'(res_bits(run_cfg.res) - 1));

  // R2
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !conv_done |=> busy);

  // R3
  done_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !done_q);

  // R3
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q && !done_clr |=> done_q);

  // R2
  finish_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done |=> !busy && done_q);

  // R4
  msb_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |=> busy && trial_code == (CODE_W'(1) << (CODE_W - 1)));

  // R10
  left_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) && run_cfg.just |-> WORD_W'(result_q << res_bits(run_cfg.res)) == '0);
endmodule

bind sar_ctrl sar_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start_pulse(start_pulse), .conv_done(conv_done),
  .done_clr(done_clr), .busy(busy), .done_q(done_q), .trial_code(trial_code),
  .result_q(result_q), .run_cfg(run_cfg)
);

// File: tb/sar_ctrl_tb.sv
module sar_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = 2'd0;
  logic [7:0]  wr_data = 8'd0;
  logic [1:0]  rd_addr = 2'd0;
  logic [7:0]  rd_data;
  logic        cmp_i;
  logic [11:0] trial_code;
  logic [11:0] vin = 12'd0;
  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  assign cmp_i = (trial_code <= vin);

  sar_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .cmp_i(cmp_i), .trial_code(trial_code)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic wr_ctrl(input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 2'd0; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic int nbits(input logic [1:0] r);
    return (r == 2'b00) ? 8 : (r == 2'b01) ? 10 : 12;
  endfunction

  function automatic int expect_word(input int v, input logic [1:0] r, input bit d, input bit j);
    int n = nbits(r);
    int val = v / (1 << (12 - n));
    if (d) val = val - (1 << (n - 1));
    if (j) return (val * (1 << (16 - n))) & 32'hFFFF;
    return val & 32'hFFFF;
  endfunction

  function automatic logic [7:0] ctrl_of(input bit d, input logic [1:0] r, input logic [1:0] m,
                                         input bit j, input bit dn, input bit b);
    return {d, r, m, j, dn, b};
  endfunction

  // start a conversion and check its timing and result
  task automatic convert(input int v, input logic [1:0] r, input bit d, input bit j);
    logic [7:0] c, hi, lo;
    int n = nbits(r);
    vin = v[11:0];
    wr_ctrl(ctrl_of(d, r, 2'b00, j, 1'b0, 1'b1));
    repeat (n - 1) @(negedge clk);
    rd(2'd0, c);
    check("R2 busy before end", int'(c[0]), 1);
    check("R3 flag low while busy", int'(c[1]), 0);
    @(negedge clk);
    rd(2'd0, c);
    check("R1 flag at edge n", int'(c[1]), 1);
    check("R2 busy clear at end", int'(c[0]), 0);
    rd(2'd1, hi);
    rd(2'd2, lo);
    check("R7 R8 R9 R10 result", int'({hi, lo}), expect_word(v, r, d, j));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL R1 watchdog actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] c, hi, lo;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R13 reset state
    rd(2'd0, c);  check("R13 ctrl reset", int'(c), 0);
    rd(2'd1, hi); check("R13 high reset", int'(hi), 0);
    rd(2'd2, lo); check("R13 low reset", int'(lo), 0);
    rd(2'd3, c);  check("R12 addr3 zero", int'(c), 0);

    // R4 MSB trial first
    vin = 12'd0;
    wr_ctrl(ctrl_of(1'b0, 2'b10, 2'b00, 1'b0, 1'b0, 1'b1));
    check("R4 first trial", int'(trial_code), 12'h800);
    repeat (12) @(negedge clk);

    // sweep all configurations (R1 R7 R8 R9 R10)
    for (int r = 0; r < 3; r++)
      for (int d = 0; d < 2; d++)
        for (int j = 0; j < 2; j++) begin
          for (int v = 0; v < 4096; v += 97) convert(v, r[1:0], d[0], j[0]);
          convert(4095, r[1:0], d[0], j[0]);
          convert(2048, r[1:0], d[0], j[0]);
          convert(2047, r[1:0], d[0], j[0]);
        end

    // R3 flag sticky, hold on write of 1, clear on write of 0
    convert(1234, 2'b10, 1'b0, 1'b0);
    repeat (5) @(negedge clk);
    rd(2'd0, c); check("R3 flag sticky", int'(c[1]), 1);
    wr_ctrl(ctrl_of(1'b0, 2'b10, 2'b00, 1'b0, 1'b1, 1'b0));
    rd(2'd0, c); check("R3 flag kept on write 1", int'(c[1]), 1);
    wr_ctrl(ctrl_of(1'b0, 2'b10, 2'b00, 1'b0, 1'b0, 1'b0));
    rd(2'd0, c); check("R3 flag cleared", int'(c[1]), 0);

    // R5 start write during conversion ignored
    vin = 12'd3000;
    wr_ctrl(ctrl_of(1'b0, 2'b10, 2'b00, 1'b0, 1'b0, 1'b1));
    repeat (3) @(negedge clk);
    wr_ctrl(ctrl_of(1'b0, 2'b10, 2'b00, 1'b0, 1'b0, 1'b1));
    repeat (12 - 5 - 1) @(negedge clk);
    rd(2'd0, c); check("R5 still busy", int'(c[0]), 1);
    @(negedge clk);
    rd(2'd0, c); check("R5 done on original schedule", int'(c[1:0]), 2'b10);
    rd(2'd1, hi); rd(2'd2, lo);
    check("R5 result intact", int'({hi, lo}), 3000);

    // R11 config writes during conversion apply to next run only
    vin = 12'd2500;
    wr_ctrl(ctrl_of(1'b1, 2'b10, 2'b00, 1'b1, 1'b0, 1'b1));
    @(negedge clk);
    wr_ctrl(ctrl_of(1'b0, 2'b00, 2'b00, 1'b0, 1'b0, 1'b0));
    repeat (12 - 3) @(negedge clk);
    rd(2'd0, c);
    check("R11 readback new fields", int'(c), int'(ctrl_of(1'b0, 2'b00, 2'b00, 1'b0, 1'b1, 1'b0)));
    rd(2'd1, hi); rd(2'd2, lo);
    check("R11 old config used", int'({hi, lo}), expect_word(2500, 2'b10, 1'b1, 1'b1));

    // R6 nonzero start mode does not start
    wr_ctrl(ctrl_of(1'b0, 2'b10, 2'b01, 1'b0, 1'b0, 1'b1));
    rd(2'd0, c); check("R6 no busy", int'(c[0]), 0);
    repeat (14) @(negedge clk);
    rd(2'd0, c); check("R6 no completion", int'(c[1]), 0);
    check("R12 ctrl layout", int'(c), int'(ctrl_of(1'b0, 2'b10, 2'b01, 1'b0, 1'b0, 1'b0)));

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule